// File: doc/BRIEF.md
# Half-Bridge Gate Interlock and Dead-Time Controller

This block turns the two switch commands of one inverter phase into two registered gate enables, one for the upper switch and one for the lower switch. The upper command is active-high and the lower command is active-low. Because of this, one PWM signal wired to both inputs gives complementary drive. A fixed decode table turns the command pair into a single request: drive the upper gate, drive the lower gate, or drive neither. Drive neither covers a conflicting pair, where both switches are asked for at once.

Two conditions block the bridge and hold both gates low: an active-low shutdown level and an undervoltage flag. After any gate turns off, or after a block clears, a dead-time counter stops either gate from turning on for `DEAD_CYC` clock cycles. Command edges that overlap, or that fall inside that window, leave the bridge off until the window has run out. Commands that arrive once the window has already passed go straight to the outputs. All four inputs pass through a synchronizer before they are used. The control pins are plain levels and have no handshake.

Top module: `hbg_gate_ctl`

## Requirements
- R1: While reset is asserted both gate outputs are 0. After reset is released, no gate turns on before rising clock edge `DEAD_CYC`+2 (counted from the first edge after release), even if a request is already steady.
- R2: When `shdn_n` is 0, both outputs are 0 from the third rising edge after the change. After `shdn_n` returns to 1, a steady request turns its gate on at exactly edge `DEAD_CYC`+2.
- R3: When `uv_flag` is 1, both outputs are 0 from the third rising edge. After it clears, a steady request turns its gate on at exactly edge `DEAD_CYC`+2.
- R4: `hi_cmd`=1 with `lo_cmd_n`=1 requests only `gate_hi`. `hi_cmd`=0 with `lo_cmd_n`=0 requests only `gate_lo`.
- R5: `hi_cmd`=1 with `lo_cmd_n`=0 (both switches asked for) drives both outputs to 0.
- R6: `hi_cmd`=0 with `lo_cmd_n`=1 drives both outputs to 0 for as long as it is held.
- R7: `gate_hi` and `gate_lo` are never 1 in the same cycle.
- R8: Whenever a gate output rises, both outputs have been 0 for at least `DEAD_CYC` consecutive cycles before it. If a gate fell because the request changed straight to the other gate, the other gate rises exactly `DEAD_CYC` edges after the fall.
- R9: When the dead-time window has already expired, a request change reaches the outputs on the third rising edge: two synchronizer stages and one output register. A gate turns off on the third edge after its request is withdrawn.
- R10: With one signal driving both `hi_cmd` and `lo_cmd_n`, the outputs are complementary, and both are 0 for `DEAD_CYC` cycles at each transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | Upper switch command, active-high |
| lo_cmd_n | input | 1 | Lower switch command, active-low |
| shdn_n | input | 1 | Shutdown level, active-low |
| uv_flag | input | 1 | Undervoltage flag, active-high |
| gate_hi | output | 1 | Upper gate enable |
| gate_lo | output | 1 | Lower gate enable |

## Verification
Every result is timed from the rising edge at which an input change is taken in.
- A turn-off, an interlock or a block reaches the outputs on the third edge.
- A gate that waits on the dead time rises `DEAD_CYC` edges after the other gate fell.
- After a block clears, or after reset, a gate rises on edge `DEAD_CYC`+2.

The directed checks count exactly that many edges from the drive point. They sample one time unit after the edge, and they also check the edge just before, where the output must not have changed yet. During random traffic, a cycle-level model of the requirements is stepped on the same edges, and both outputs are compared with it half a period later.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_HIGH = 2'd1,
    REQ_LOW  = 2'd2
  } req_e;

  // Truth table of the command pair (upper active-high, lower active-low)
  function automatic req_e decode_req(input logic hi, input logic lo_n);
    if (hi && lo_n)        return REQ_HIGH;
    else if (!hi && !lo_n) return REQ_LOW;
    else                   return REQ_NONE;
  endfunction
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
        else        chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime #(
  parameter int DEAD_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  output logic open
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= LOAD;
    else if (hold || restart) cnt <= LOAD;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign open = (cnt == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD); // R8
  AST_RESTART_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !open); // R8
  AST_HOLD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !open); // R3
endmodule

// File: rtl/hbg_gate_ctl.sv
module hbg_gate_ctl #(
  parameter int DEAD_CYC    = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd_n,
  input  logic shdn_n,
  input  logic uv_flag,
  output logic gate_hi,
  output logic gate_lo
);
  import hbg_pkg::*;

  localparam int NIN = 4;
  localparam int RW  = $clog2(DEAD_CYC + 2);
  // reset values: hi=0, lo_n=1, shdn_n=0, uv=1 -> blocked, no request
  localparam logic [NIN-1:0] SYNC_RST = 4'b0101;

  logic [NIN-1:0] raw_in, syn;
  logic s_hi, s_lon, s_sd, s_uv;
  req_e req;
  logic blk, want_h, want_l, open, gh_d, gl_d, fall;

  assign raw_in = {hi_cmd, lo_cmd_n, shdn_n, uv_flag};

  hbg_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(syn)
  );

  assign {s_hi, s_lon, s_sd, s_uv} = syn;

  always_comb begin
    req    = decode_req(s_hi, s_lon);
    blk    = !s_sd || s_uv;
    want_h = (req == REQ_HIGH) && !blk;
    want_l = (req == REQ_LOW)  && !blk;
    // a gate may start only when the other is off and the window is over
    gh_d   = want_h && (gate_hi || (open && !gate_lo));
    gl_d   = want_l && (gate_lo || (open && !gate_hi));
    fall   = (gate_hi && !gh_d) || (gate_lo && !gl_d);
  end

  hbg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_n), .hold(blk), .restart(fall), .open(open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= gh_d;
      gate_lo <= gl_d;
    end
  end

  // checker state: consecutive cycles with both gates off
  logic [RW-1:0] idle_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idle_run <= '0;
    else if (gate_hi || gate_lo)  idle_run <= '0;
    else if (idle_run != '1)      idle_run <= idle_run + 1'b1;
  end

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R7
  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sd |=> !gate_hi && !gate_lo); // R2
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    s_uv |=> !gate_hi && !gate_lo); // R3
  AST_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hi && !s_lon) |=> !gate_hi && !gate_lo); // R5
  AST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_hi && s_lon) |=> !gate_hi && !gate_lo); // R6
  AST_HI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(s_hi && s_lon)); // R4
  AST_LO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> $past(!s_hi && !s_lon)); // R4
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (idle_run >= RW'(DEAD_CYC))); // R8
endmodule

// File: tb/hbg_gate_ctl_test.sv
module hbg_gate_ctl_test;
  localparam int DEAD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd = 1'b1, lo_cmd_n = 1'b1, shdn_n = 1'b1, uv_flag = 1'b0;
  logic gate_hi, gate_lo;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  hbg_gate_ctl #(.DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
    .shdn_n(shdn_n), .uv_flag(uv_flag), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // expected request from the table of R4..R6: 1 upper, 2 lower, 0 none
  function automatic int exp_req(logic hi, logic lo_n);
    if (hi && lo_n)   return 1;
    if (!hi && !lo_n) return 2;
    return 0;
  endfunction

  function automatic string tag_for(logic [3:0] s);
    if (s[1] == 1'b0) return "R2";
    if (s[0] == 1'b1) return "R3";
    if (s[3] && !s[2]) return "R5";
    if (!s[3] && s[2]) return "R6";
    return "R4/R8";
  endfunction

  // cycle model of the requirements: inputs seen after two stages
  logic [3:0] m1, m2;
  int  mwin;
  logic mh, ml;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 4'b0101; m2 <= 4'b0101; mwin <= DEAD - 1; mh <= 1'b0; ml <= 1'b0;
    end else begin
      int  rq;
      logic blocked, nh, nl;
      rq      = exp_req(m2[3], m2[2]);
      blocked = !m2[1] || m2[0];
      nh = (rq == 1) && !blocked && (mh || (mwin == 0 && !ml));
      nl = (rq == 2) && !blocked && (ml || (mwin == 0 && !mh));
      if (blocked || (mh && !nh) || (ml && !nl)) mwin <= DEAD - 1;
      else if (mwin != 0) mwin <= mwin - 1;
      mh <= nh; ml <= nl;
      m1 <= {hi_cmd, lo_cmd_n, shdn_n, uv_flag};
      m2 <= m1;
    end
  end

  task automatic chk(string tag, logic ah, logic al, logic eh, logic el);
    n_chk++;
    if (ah !== eh || al !== el) begin
      n_bad++;
      $display("FAIL %s: gate_hi/gate_lo = %b%b, expected %b%b at %0t",
               tag, ah, al, eh, el, $time);
    end
  endtask

  // continuous comparison against the model and gap measurement, half a period after the edge
  int  idle = 0;
  logic ph = 1'b0, pl = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_for(m2), gate_hi, gate_lo, mh, ml);
      chk("R7", gate_hi && gate_lo, 1'b0, 1'b0, 1'b0);
      if ((gate_hi && !ph) || (gate_lo && !pl)) begin
        n_chk++;
        if (idle < DEAD) begin
          n_bad++;
          $display("FAIL R8: off gap %0d before rise, expected >= %0d", idle, DEAD);
        end
      end
      if (gate_hi || gate_lo) idle = 0; else idle++;
      ph = gate_hi; pl = gate_lo;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(logic h, logic ln);
    hi_cmd = h; lo_cmd_n = ln;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state, with the upper request already present
    repeat (3) @(posedge clk);
    #1;
    chk("R1", gate_hi, gate_lo, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(DEAD + 1);
    chk("R1", gate_hi, gate_lo, 1'b0, 1'b0);
    step(1);
    chk("R1", gate_hi, gate_lo, 1'b1, 1'b0);

    // R9: withdrawal seen on third edge
    drive(1'b0, 1'b1);
    step(2);
    chk("R9", gate_hi, gate_lo, 1'b1, 1'b0);
    step(1);
    chk("R9", gate_hi, gate_lo, 1'b0, 1'b0);
    // R6: no request held
    step(DEAD + 5);
    chk("R6", gate_hi, gate_lo, 1'b0, 1'b0);
    // R9: window already expired -> direct pass on third edge
    drive(1'b0, 1'b0);
    step(2);
    chk("R9", gate_hi, gate_lo, 1'b0, 1'b0);
    step(1);
    chk("R9", gate_hi, gate_lo, 1'b0, 1'b1);

    // R10: tied inputs switching low->high side
    drive(1'b1, 1'b1);
    step(3);
    chk("R10", gate_hi, gate_lo, 1'b0, 1'b0);
    step(DEAD - 1);
    chk("R10", gate_hi, gate_lo, 1'b0, 1'b0);
    step(1);
    chk("R10", gate_hi, gate_lo, 1'b1, 1'b0);
    // R10/R8: back to low side
    drive(1'b0, 1'b0);
    step(3 + DEAD - 1);
    chk("R8", gate_hi, gate_lo, 1'b0, 1'b0);
    step(1);
    chk("R8", gate_hi, gate_lo, 1'b0, 1'b1);

    // R5: conflicting pair
    drive(1'b1, 1'b0);
    step(3);
    chk("R5", gate_hi, gate_lo, 1'b0, 1'b0);
    step(DEAD + 4);
    chk("R5", gate_hi, gate_lo, 1'b0, 1'b0);
    drive(1'b1, 1'b1);
    step(3);
    chk("R4", gate_hi, gate_lo, 1'b1, 1'b0);

    // R3: undervoltage and its release
    uv_flag = 1'b1;
    step(2);
    chk("R3", gate_hi, gate_lo, 1'b1, 1'b0);
    step(1);
    chk("R3", gate_hi, gate_lo, 1'b0, 1'b0);
    step(10);
    uv_flag = 1'b0;
    step(DEAD + 1);
    chk("R3", gate_hi, gate_lo, 1'b0, 1'b0);
    step(1);
    chk("R3", gate_hi, gate_lo, 1'b1, 1'b0);

    // R2: shutdown and its release
    shdn_n = 1'b0;
    step(3);
    chk("R2", gate_hi, gate_lo, 1'b0, 1'b0);
    drive(1'b0, 1'b0);
    step(8);
    chk("R2", gate_hi, gate_lo, 1'b0, 1'b0);
    shdn_n = 1'b1;
    step(DEAD + 1);
    chk("R2", gate_hi, gate_lo, 1'b0, 1'b0);
    step(1);
    chk("R2", gate_hi, gate_lo, 1'b0, 1'b1);

    // random traffic, checked each cycle against the model
    for (int i = 0; i < 8000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6)       hi_cmd = $urandom_range(0, 1);
      else if (r < 12) lo_cmd_n = $urandom_range(0, 1);
      else if (r < 18) begin hi_cmd = $urandom_range(0, 1); lo_cmd_n = hi_cmd; end
      else if (r == 18) shdn_n = 1'b0;
      else if (r == 19) uv_flag = 1'b1;
      else if (r < 30) begin shdn_n = 1'b1; uv_flag = 1'b0; end
      step($urandom_range(1, 2 * DEAD));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule